// File: doc/BRIEF.md
# Serial Link Power-Mode Controller

This block decides which operating mode a single-wire serial vehicle network link controller is in. The modes are reset, run, clocked wait, clock-stopped stop, digital loopback and analog loopback. Inputs are the CPU wait and stop instruction strobes, a configuration bit that turns a wait instruction into a stop, two loopback selects, the raw bus receive line, a valid end-of-frame pulse from the receiver and a transmit-busy flag. Outputs are the mode code, an enable for the controller's internal clocks, a sticky wake interrupt, a loopback path select, and an enable that allows the link to take part on the bus.

Wake-up from wait has two sources: a passive-to-active edge on the bus, or a valid end-of-frame. Wake-up from stop has only one source, bus activity, which is caught by a latch that needs no clock. That latch is clocked by the receive line itself and is then synchronised into the clock domain. The link may take part on the bus only after the receive line has stayed passive for a programmable number of cycles. That count starts again whenever analog loopback is left.

Top module: `slink_pwr_ctl`

## Requirements
- R1: The mode code is 0 (reset) in the cycle after any bit of `rst_src` is high, from any mode. It becomes 1 (run) one cycle after every bit of `rst_src` is low.
- R2: In run, a `wait_insn` pulse moves the mode on the next edge. It goes to 2 (wait) when `wait_to_stop` is 0 and to 3 (stop) when `wait_to_stop` is 1.
- R3: In run, a `stop_insn` pulse moves the mode to 3 (stop) on the next edge, whatever the value of `wait_to_stop`.
- R4: In wait, `clk_en` stays 1. A 0-to-1 change on `rx_pin` (1 means active) passes through a two-flop synchroniser. On the third rising clock edge after the change, the mode returns to run and `wake_irq` is set.
- R5: In wait, an `eof_ok` pulse returns the mode to run and sets `wake_irq` on the next edge.
- R6: In stop, `clk_en` is 0. Any rising edge on `rx_pin` is latched without a clock, even a pulse shorter than a clock period. On the third rising clock edge after it, the mode returns to run, `clk_en` returns to 1 and `wake_irq` is set.
- R7: A high `dig_lb` in run selects mode 4 (digital loopback) on the next edge. In that mode `lb_sel` is 1, `tx_pin` is held at 0 (passive) and `rx_core` equals `tx_core`. In every other mode `tx_pin` equals `tx_core` and `rx_core` is the synchronised `rx_pin`. The mode returns to run one cycle after `dig_lb` falls.
- R8: `wake_irq` stays set until a cycle with `wake_ack` high, and then clears on the next edge. A new wake event in the same cycle as the acknowledge wins.
- R9: `bus_en` is 1 only in run or analog loopback, and only once the synchronised receive line has been passive for `IDLE_CYC` consecutive cycles. Any active sample restarts the count.
- R10: A high `ana_lb` in run selects mode 5 (analog loopback), where `lb_sel` stays 0 and `tx_pin` follows `tx_core`. When `ana_lb` falls, the mode returns to run and the idle count restarts from zero, so `bus_en` rises again only `IDLE_CYC` edges after the exit edge.
- R11: A wait or stop request that arrives while `tx_busy` is 1 leaves the mode in run and is held pending. It takes effect on the edge after `tx_busy` falls.
- R12: In run, `dig_lb` has priority over `ana_lb`, and both have priority over a pending or new wait/stop request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| rst_src | input | N_RST | Reset sources, one bit each, active high |
| wait_insn | input | 1 | CPU wait instruction strobe |
| stop_insn | input | 1 | CPU stop instruction strobe |
| wait_to_stop | input | 1 | 1 makes a wait instruction enter stop |
| dig_lb | input | 1 | Digital loopback select |
| ana_lb | input | 1 | Analog loopback select |
| rx_pin | input | 1 | Asynchronous bus receive line, 1 = active |
| eof_ok | input | 1 | Valid end-of-frame pulse from the receiver |
| tx_busy | input | 1 | A transmission is in progress |
| tx_core | input | 1 | Transmit bit from the link controller |
| wake_ack | input | 1 | Single-cycle wake interrupt acknowledge |
| mode | output | 3 | Mode: 0 reset, 1 run, 2 wait, 3 stop, 4 digital loopback, 5 analog loopback |
| clk_en | output | 1 | Enable for the controller's internal clocks |
| wake_irq | output | 1 | Sticky wake interrupt request |
| lb_sel | output | 1 | 1 ties the transmit path to the receive path internally |
| bus_en | output | 1 | Link may take part on the bus |
| tx_pin | output | 1 | Transmit line toward the transceiver |
| rx_core | output | 1 | Receive bit toward the link controller |

## Verification
The bench builds the block with `N_RST = 2` and `IDLE_CYC = 6`. Two reset sources are enough to show that the block stays in reset until the last source releases. A short idle window lets the bench count the exact edge on which `bus_en` rises, both after bus traffic and after leaving analog loopback. With these values the rise falls well inside one stimulus step, so the bench can also check the cycle just before it. The wake paths are checked on the exact third edge after a receive change, and a sub-period pulse checks that the stop-mode latch needs no clock.

// File: rtl/slink_pwr_ctl.sv
module slink_pwr_ctl #(
  parameter int N_RST    = 2,
  parameter int IDLE_CYC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_RST-1:0] rst_src,
  input  logic             wait_insn,
  input  logic             stop_insn,
  input  logic             wait_to_stop,
  input  logic             dig_lb,
  input  logic             ana_lb,
  input  logic             rx_pin,
  input  logic             eof_ok,
  input  logic             tx_busy,
  input  logic             tx_core,
  input  logic             wake_ack,
  output logic [2:0]       mode,
  output logic             clk_en,
  output logic             wake_irq,
  output logic             lb_sel,
  output logic             bus_en,
  output logic             tx_pin,
  output logic             rx_core
);

  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_CYC);
  localparam logic [2:0] M_RESET = 3'd0, M_RUN = 3'd1, M_WAIT = 3'd2,
                         M_STOP = 3'd3, M_DLB = 3'd4, M_ALB = 3'd5;

  logic rx_s1, rx_s2, rx_q;
  logic act_lat, act_s1, act_s2;
  logic pend_w, pend_s;
  logic [CW-1:0] idle_cnt;
  logic [2:0] nxt;
  logic wake_set, alb_exit;

  wire in_stop   = (mode == M_STOP);
  wire act_clr   = ~in_stop | ~rst_n;
  wire rx_rise   = rx_s2 & ~rx_q;
  wire sleep_req = wait_insn | stop_insn | pend_w | pend_s;
  wire to_stop   = stop_insn | pend_s | wait_to_stop;
  wire idle      = (idle_cnt == IDLE_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rx_s1, rx_s2, rx_q} <= '0;
    else        {rx_s1, rx_s2, rx_q} <= {rx_pin, rx_s1, rx_s2};

  always_ff @(posedge rx_pin or posedge act_clr)
    if (act_clr) act_lat <= 1'b0;
    else         act_lat <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       {act_s1, act_s2} <= '0;
    else if (!in_stop) {act_s1, act_s2} <= '0;
    else              {act_s1, act_s2} <= {act_lat, act_s1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                idle_cnt <= '0;
    else if (alb_exit | rx_s2) idle_cnt <= '0;
    else if (!idle)            idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_w <= 1'b0;
      pend_s <= 1'b0;
    end else if (mode != M_RUN || nxt != M_RUN) begin
      pend_w <= 1'b0;
      pend_s <= 1'b0;
    end else if (tx_busy) begin
      pend_w <= pend_w | wait_insn;
      pend_s <= pend_s | stop_insn;
    end

  always_comb begin
    nxt      = mode;
    wake_set = 1'b0;
    alb_exit = 1'b0;
    if (|rst_src) nxt = M_RESET;
    else case (mode)
      M_RESET: nxt = M_RUN;
      M_RUN:
        if (dig_lb)                    nxt = M_DLB;
        else if (ana_lb)               nxt = M_ALB;
        else if (sleep_req && !tx_busy) nxt = to_stop ? M_STOP : M_WAIT;
      M_WAIT:
        if (rx_rise | eof_ok) begin
          nxt      = M_RUN;
          wake_set = 1'b1;
        end
      M_STOP:
        if (act_s2) begin
          nxt      = M_RUN;
          wake_set = 1'b1;
        end
      M_DLB: if (!dig_lb) nxt = M_RUN;
      M_ALB:
        if (!ana_lb) begin
          nxt      = M_RUN;
          alb_exit = 1'b1;
        end
      default: nxt = M_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode     <= M_RESET;
      wake_irq <= 1'b0;
    end else begin
      mode     <= nxt;
      wake_irq <= wake_set | (wake_irq & ~wake_ack);
    end

  assign clk_en  = ~in_stop;
  assign lb_sel  = (mode == M_DLB);
  assign bus_en  = ((mode == M_RUN) | (mode == M_ALB)) & idle;
  assign tx_pin  = lb_sel ? 1'b0 : tx_core;
  assign rx_core = lb_sel ? tx_core : rx_s2;

endmodule

// File: rtl/slink_pwr_ctl_chk.sv
module slink_pwr_ctl_chk #(
  parameter int N_RST = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_RST-1:0] rst_src,
  input logic             wait_insn,
  input logic             stop_insn,
  input logic             wait_to_stop,
  input logic             dig_lb,
  input logic             ana_lb,
  input logic             eof_ok,
  input logic             tx_busy,
  input logic             tx_core,
  input logic             wake_ack,
  input logic             pend_w,
  input logic             pend_s,
  input logic [2:0]       mode,
  input logic             wake_irq,
  input logic             bus_en,
  input logic             tx_pin,
  input logic             rx_core
);
  localparam logic [2:0] C_RESET = 3'd0, C_RUN = 3'd1, C_WAIT = 3'd2,
                         C_STOP = 3'd3, C_DLB = 3'd4, C_ALB = 3'd5;

  wire quiet_run = (mode == C_RUN) && (rst_src == '0) && !dig_lb && !ana_lb;

  p_reset_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|rst_src) |=> (mode == C_RESET));

  p_wait_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_run && wait_insn && !stop_insn && !wait_to_stop && !tx_busy && !pend_s)
      |=> (mode == C_WAIT));

  p_stop_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_run && stop_insn && !tx_busy) |=> (mode == C_STOP));

  p_eof_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == C_WAIT) && eof_ok && (rst_src == '0)) |=> ((mode == C_RUN) && wake_irq));

  p_dlb_tie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == C_DLB) |-> (!tx_pin && (rx_core == tx_core)));

  p_wake_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !wake_ack) |=> wake_irq);

  p_bus_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> ((mode == C_RUN) || (mode == C_ALB)));

  p_alb_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == C_ALB) && !ana_lb && (rst_src == '0)) |=> !bus_en);

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_run && tx_busy) |=> (mode == C_RUN));

  p_dlb_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == C_RUN) && (rst_src == '0) && dig_lb) |=> (mode == C_DLB));
endmodule

bind slink_pwr_ctl slink_pwr_ctl_chk #(.N_RST(N_RST)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_src(rst_src), .wait_insn(wait_insn),
  .stop_insn(stop_insn), .wait_to_stop(wait_to_stop), .dig_lb(dig_lb),
  .ana_lb(ana_lb), .eof_ok(eof_ok), .tx_busy(tx_busy), .tx_core(tx_core),
  .wake_ack(wake_ack), .pend_w(pend_w), .pend_s(pend_s), .mode(mode),
  .wake_irq(wake_irq), .bus_en(bus_en), .tx_pin(tx_pin), .rx_core(rx_core)
);

// File: tb/tb_slink_pwr_ctl.sv
module tb_slink_pwr_ctl;
  localparam int NR = 2;
  localparam int IC = 6;
  localparam logic [2:0] K_RESET = 3'd0, K_RUN = 3'd1, K_WAIT = 3'd2,
                         K_STOP = 3'd3, K_DLB = 3'd4, K_ALB = 3'd5;
  localparam logic [8:0] MK_MODE = 9'h007, MK_CE = 9'h008, MK_WK = 9'h010,
                         MK_LB = 9'h020, MK_BE = 9'h040, MK_TXP = 9'h080,
                         MK_RXC = 9'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0] rst_src = '1;
  logic wait_insn = 0, stop_insn = 0, wait_to_stop = 0, dig_lb = 0, ana_lb = 0;
  logic rx_pin = 0, eof_ok = 0, tx_busy = 0, tx_core = 0, wake_ack = 0;
  logic [2:0] mode;
  logic clk_en, wake_irq, lb_sel, bus_en, tx_pin, rx_core;

  always #4 clk = ~clk;

  slink_pwr_ctl #(.N_RST(NR), .IDLE_CYC(IC)) dut (
    .clk(clk), .rst_n(rst_n), .rst_src(rst_src), .wait_insn(wait_insn),
    .stop_insn(stop_insn), .wait_to_stop(wait_to_stop), .dig_lb(dig_lb),
    .ana_lb(ana_lb), .rx_pin(rx_pin), .eof_ok(eof_ok), .tx_busy(tx_busy),
    .tx_core(tx_core), .wake_ack(wake_ack), .mode(mode), .clk_en(clk_en),
    .wake_irq(wake_irq), .lb_sel(lb_sel), .bus_en(bus_en), .tx_pin(tx_pin),
    .rx_core(rx_core)
  );

  typedef struct {
    string      tag;
    logic [8:0] mask;
    logic [8:0] val;
  } exp_t;

  exp_t exp_q[$];
  event ev_push;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_o(input string tag, input logic [8:0] mask,
                          input logic [2:0] m, input logic ce, input logic wk,
                          input logic lb, input logic be, input logic txp,
                          input logic rxc);
    exp_t e;
    e.tag  = tag;
    e.mask = mask;
    e.val  = {rxc, txp, be, lb, wk, ce, m};
    exp_q.push_back(e);
    ->ev_push;
    #0;
  endtask

  initial forever begin
    @(ev_push);
    while (exp_q.size() != 0) begin
      exp_t e;
      logic [8:0] obs;
      e = exp_q.pop_front();
      obs = {rx_core, tx_pin, bus_en, lb_sel, wake_irq, clk_en, mode};
      n_chk++;
      if ((obs & e.mask) !== (e.val & e.mask)) begin
        n_fail++;
        $display("FAIL %s: actual %b expected %b (mask %b)", e.tag, obs & e.mask,
                 e.val & e.mask, e.mask);
      end
    end
  end

  task automatic pulse(ref logic s);
    s = 1'b1;
    tick(1);
    s = 1'b0;
  endtask

  task automatic ack;
    wake_ack = 1'b1;
    tick(1);
    wake_ack = 1'b0;
    expect_o("R8 ack clears wake", MK_WK, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    expect_o("R1 reset state", MK_MODE | MK_WK | MK_BE | MK_LB, K_RESET, 0, 0, 0, 0, 0, 0);
    rst_src = 2'b01;
    tick(3);
    expect_o("R1 one source still held", MK_MODE, K_RESET, 0, 0, 0, 0, 0, 0);
    rst_src = 2'b00;
    tick(1);
    expect_o("R1 run after release", MK_MODE | MK_CE, K_RUN, 1, 0, 0, 0, 0, 0);
    expect_o("R9 idle bus enables", MK_BE, 0, 0, 0, 0, 1, 0, 0);

    rx_pin = 1'b1;
    tick(4);
    expect_o("R9 activity drops bus_en", MK_BE, 0, 0, 0, 0, 0, 0, 0);
    rx_pin = 1'b0;
    tick(IC + 1);
    expect_o("R9 one short of idle", MK_BE, 0, 0, 0, 0, 0, 0, 0);
    tick(1);
    expect_o("R9 idle reached", MK_BE, 0, 0, 0, 0, 1, 0, 0);

    wait_to_stop = 1'b0;
    pulse(wait_insn);
    expect_o("R2 wait entry", MK_MODE | MK_CE, K_WAIT, 1, 0, 0, 0, 0, 0);
    tick(3);
    expect_o("R4 quiet bus keeps wait", MK_MODE | MK_WK, K_WAIT, 0, 0, 0, 0, 0, 0);
    rx_pin = 1'b1;
    tick(2);
    expect_o("R4 still wait before sync", MK_MODE, K_WAIT, 0, 0, 0, 0, 0, 0);
    tick(1);
    expect_o("R4 bus edge wakes", MK_MODE | MK_WK | MK_CE, K_RUN, 1, 1, 0, 0, 0, 0);
    tick(2);
    expect_o("R8 wake sticky", MK_WK, 0, 0, 1, 0, 0, 0, 0);
    ack();
    rx_pin = 1'b0;
    tick(4);

    pulse(wait_insn);
    expect_o("R2 wait entry again", MK_MODE, K_WAIT, 0, 0, 0, 0, 0, 0);
    pulse(eof_ok);
    expect_o("R5 end-of-frame wakes", MK_MODE | MK_WK, K_RUN, 0, 1, 0, 0, 0, 0);
    ack();

    wait_to_stop = 1'b1;
    pulse(wait_insn);
    expect_o("R2 wait with config enters stop", MK_MODE | MK_CE, K_STOP, 0, 0, 0, 0, 0, 0);
    rx_pin = 1'b1;
    tick(2);
    expect_o("R6 clocks still off", MK_MODE | MK_CE, K_STOP, 0, 0, 0, 0, 0, 0);
    tick(1);
    expect_o("R6 activity restarts clocks", MK_MODE | MK_CE | MK_WK, K_RUN, 1, 1, 0, 0, 0, 0);
    ack();
    rx_pin = 1'b0;
    tick(4);

    wait_to_stop = 1'b0;
    pulse(stop_insn);
    expect_o("R3 stop ignores config", MK_MODE | MK_CE, K_STOP, 0, 0, 0, 0, 0, 0);
    tick(2);
    rx_pin = 1'b1;
    #1 rx_pin = 1'b0;
    tick(2);
    expect_o("R6 glitch latched, still stop", MK_MODE, K_STOP, 0, 0, 0, 0, 0, 0);
    tick(1);
    expect_o("R6 glitch wakes", MK_MODE | MK_CE | MK_WK, K_RUN, 1, 1, 0, 0, 0, 0);
    ack();
    tick(2);

    tx_busy = 1'b1;
    pulse(wait_insn);
    tick(2);
    expect_o("R11 busy defers wait", MK_MODE, K_RUN, 0, 0, 0, 0, 0, 0);
    tx_busy = 1'b0;
    tick(1);
    expect_o("R11 deferred wait taken", MK_MODE, K_WAIT, 0, 0, 0, 0, 0, 0);
    pulse(eof_ok);
    ack();

    wait_to_stop = 1'b0;
    dig_lb = 1'b1;
    ana_lb = 1'b1;
    wait_insn = 1'b1;
    tx_core = 1'b1;
    tick(1);
    wait_insn = 1'b0;
    ana_lb = 1'b0;
    expect_o("R12 digital loopback wins", MK_MODE, K_DLB, 0, 0, 0, 0, 0, 0);
    expect_o("R7 loop tie high", MK_LB | MK_TXP | MK_RXC | MK_BE, 0, 0, 0, 1, 0, 0, 1);
    tx_core = 1'b0;
    rx_pin = 1'b1;
    tick(3);
    expect_o("R7 bus ignored in loopback", MK_RXC | MK_TXP, 0, 0, 0, 0, 0, 0, 0);
    dig_lb = 1'b0;
    tx_core = 1'b1;
    tick(1);
    expect_o("R7 path restored", MK_MODE | MK_LB | MK_TXP | MK_RXC, K_RUN, 0, 0, 0, 0, 1, 1);
    rx_pin = 1'b0;
    tx_core = 1'b0;
    tick(IC + 3);

    ana_lb = 1'b1;
    tx_core = 1'b1;
    tick(1);
    expect_o("R10 analog loopback", MK_MODE | MK_LB | MK_TXP | MK_BE, K_ALB, 0, 0, 0, 1, 1, 0);
    ana_lb = 1'b0;
    tx_core = 1'b0;
    tick(1);
    expect_o("R10 exit blocks bus", MK_MODE | MK_BE, K_RUN, 0, 0, 0, 0, 0, 0);
    tick(IC - 1);
    expect_o("R10 one short of idle", MK_BE, 0, 0, 0, 0, 0, 0, 0);
    tick(1);
    expect_o("R10 idle after exit", MK_BE, 0, 0, 0, 0, 1, 0, 0);

    pulse(wait_insn);
    rx_pin = 1'b1;
    tick(2);
    eof_ok = 1'b1;
    wake_ack = 1'b1;
    tick(1);
    eof_ok = 1'b0;
    wake_ack = 1'b0;
    expect_o("R8 new wake beats ack", MK_WK | MK_MODE, K_RUN, 0, 1, 0, 0, 0, 0);
    ack();
    rx_pin = 1'b0;

    rst_src = 2'b10;
    tick(1);
    expect_o("R1 reset from run", MK_MODE | MK_BE, K_RESET, 0, 0, 0, 0, 0, 0);
    rst_src = 2'b00;
    tick(1);
    expect_o("R1 run again", MK_MODE, K_RUN, 0, 0, 0, 0, 0, 0);
    tick(2);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule